// File: doc/BRIEF.md
# GPIO Bank Register File

This block holds the control and interrupt state of one bank of general-purpose pins, organised as a set of ports of eight pins each (four ports, 32 pins by default). A host reaches it over a plain bus with separate read and write strobes and a byte address. For each port it keeps a pin-ownership (configuration) register, a drive-enable register, an output-value register, a synchronized view of the pad inputs, and the interrupt status, enable and trigger-type registers. Its pad-facing outputs and its interrupt state outputs feed the pad ring and the interrupt sense logic.

Every writable register except the clear-only status port can be reached a second time through a masked alias. A write there changes only the pins whose enable bit is set, so software can own a single pin without a read-modify-write sequence. The interrupt sense logic sets status bits through a per-pin set input. Software clears them through a write-ones-to-clear address.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every register reads zero, and pad_oe, pad_out, int_sta, int_enb and int_lvl are all zero.
- R2: Register groups sit at byte offsets 0x00 (configuration), 0x10 (drive enable), 0x20 (output value), 0x30 (input), 0x40 (status), 0x50 (interrupt enable), 0x60 (trigger type) and 0x70 (status clear), with port p at +4*p. A read loads rd_data at the clock edge that samples rd_en. The value is held until the next read. Bits above a register's width read zero.
- R3: Each 8-bit writable register has a masked alias at its offset plus 0x80. A write there updates pin i from wdata[i] only when wdata[8+i] is 1, and every other pin keeps its value. A read of the alias returns the plain register.
- R4: The trigger-type register is 24 bits, with pin i's fields at bits i, i+8 and i+16. Its masked alias takes the per-pin enables in wdata[31:24] and applies enable i to bits i, i+8 and i+16, with the new values taken from wdata[23:0].
- R5: Pin n is port n/8, bit n%8. pad_oe[n] is 1 exactly when both its configuration bit and its drive-enable bit are 1. pad_out[n] equals the output-value bit when pad_oe[n] is 1 and is 0 otherwise. The pad outputs change in the cycle after the write.
- R6: The input register returns pad_in through a two-flop synchronizer, so a pad change is readable by a read issued on the third rising edge after it. The input register is read-only, and writes to it are ignored.
- R7: Writing ones to the status-clear register clears those status bits, and a read of it returns zero. A plain write to the status register loads it, and its masked alias follows R3.
- R8: A 1 on int_set[n] sets status bit n at the next edge, and this set wins over a clear or status write to the same bit in the same cycle.
- R9: Unmapped addresses read zero and ignore writes. These are offsets of 0x100 and above, offsets not a multiple of 4, and the masked aliases of the input and status-clear registers.
- R10: int_sta and int_enb give the 32 status and enable bits by pin number. int_lvl packs port p's trigger-type register at bits [24p+23:24p].
- R11: A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables |
| int_set | input | 32 | Per-pin status set from sense logic |
| int_sta | output | 32 | Interrupt status by pin |
| int_enb | output | 32 | Interrupt enable by pin |
| int_lvl | output | 96 | Trigger-type fields, 24 bits per port |

## Verification
Register writes take effect at the edge that samples wr_en, so pad and interrupt outputs are compared at the falling edge that follows. Read data is due one edge after rd_en. The driver queues each expected read word, and the monitor compares it at the falling edge after the capturing edge. A pad input change passes through two synchronizer flops before the capturing read edge, so the bench waits three edges before issuing that read. Status set and clear collisions are driven in one cycle and read back afterwards.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int BYTE_W = 8;
   localparam int LVL_W  = 3 * BYTE_W;
   localparam int BUS_W  = 32;

   typedef enum logic [2:0] {
      GRP_CNF = 3'd0,
      GRP_OE  = 3'd1,
      GRP_OUT = 3'd2,
      GRP_IN  = 3'd3,
      GRP_STA = 3'd4,
      GRP_ENB = 3'd5,
      GRP_LVL = 3'd6,
      GRP_CLR = 3'd7
   } grp_e;

   // byte register update through the masked alias: enables in [15:8]
   function automatic logic [BYTE_W-1:0] merge_byte(input logic [BYTE_W-1:0] cur,
                                                    input logic [BUS_W-1:0]  wd);
      return (cur & ~wd[15:8]) | (wd[7:0] & wd[15:8]);
   endfunction

   // trigger-type update through the masked alias: enables in [31:24]
   function automatic logic [LVL_W-1:0] merge_lvl(input logic [LVL_W-1:0] cur,
                                                  input logic [BUS_W-1:0] wd);
      logic [LVL_W-1:0] en;
      en = {3{wd[31:24]}};
      return (cur & ~en) | (wd[LVL_W-1:0] & en);
   endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int PORTS    = 4,
   parameter int MASK_OFS = 'h80
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output grp_e              grp,
   output logic [1:0]        port,
   output logic              masked
);

   localparam logic [ADDR_W-1:0] MASK_BIT = ADDR_W'(MASK_OFS);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if ((MASK_OFS < 'h80) || ((MASK_OFS & (MASK_OFS - 1)) != 0) || (MASK_OFS >= (1 << ADDR_W))) begin : g_bad_mask
      $error("MASK_OFS must be a power of two in [0x80, 2**ADDR_W)");
   end
   if ((PORTS < 1) || (PORTS > 4)) begin : g_bad_ports
      $error("PORTS must be 1..4");
   end

   logic [ADDR_W-1:0] base;
   logic              in_range;
   logic              alias_ok;

   always_comb begin
      base     = addr & ~MASK_BIT;
      masked   = |(addr & MASK_BIT);
      grp      = grp_e'(base[6:4]);
      port     = base[3:2];
      in_range = (base[ADDR_W-1:7] == '0) && (addr[1:0] == 2'b00);
      alias_ok = !masked || ((grp != GRP_IN) && (grp != GRP_CLR));
      hit      = in_range && alias_ok && ({30'd0, port} < 32'(PORTS));
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_bank_pkg::*;
#(
   parameter int PORT_PINS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_sel,
   input  grp_e                 grp,
   input  logic                 masked,
   input  logic [BUS_W-1:0]     wdata,
   input  logic [PORT_PINS-1:0] set_i,
   output logic [PORT_PINS-1:0] cnf,
   output logic [PORT_PINS-1:0] oe,
   output logic [PORT_PINS-1:0] out,
   output logic [PORT_PINS-1:0] sta,
   output logic [PORT_PINS-1:0] enb,
   output logic [LVL_W-1:0]     lvl
);

   if (PORT_PINS != BYTE_W) begin : g_bad_pins
      $error("PORT_PINS must be 8: the masked write layout depends on it");
   end

   logic [PORT_PINS-1:0] sta_n;

   always_comb begin
      sta_n = sta;
      if (wr_sel && (grp == GRP_STA))
         sta_n = masked ? merge_byte(sta, wdata) : wdata[PORT_PINS-1:0];
      if (wr_sel && (grp == GRP_CLR) && !masked)
         sta_n = sta & ~wdata[PORT_PINS-1:0];
      sta_n = sta_n | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnf <= '0;
         oe  <= '0;
         out <= '0;
         sta <= '0;
         enb <= '0;
         lvl <= '0;
      end else begin
         sta <= sta_n;
         if (wr_sel) begin
            case (grp)
               GRP_CNF: cnf <= masked ? merge_byte(cnf, wdata) : wdata[PORT_PINS-1:0];
               GRP_OE:  oe  <= masked ? merge_byte(oe,  wdata) : wdata[PORT_PINS-1:0];
               GRP_OUT: out <= masked ? merge_byte(out, wdata) : wdata[PORT_PINS-1:0];
               GRP_ENB: enb <= masked ? merge_byte(enb, wdata) : wdata[PORT_PINS-1:0];
               GRP_LVL: lvl <= masked ? merge_lvl(lvl, wdata)  : wdata[LVL_W-1:0];
               default: ;
            endcase
         end
      end
   end

   // R3
   masked_cnf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && masked && grp == GRP_CNF) |=> (((cnf ^ $past(cnf)) & ~$past(wdata[15:8])) == '0));

   // R3
   masked_out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && masked && grp == GRP_OUT) |=> (((out ^ $past(out)) & ~$past(wdata[15:8])) == '0));

   // R4
   masked_lvl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && masked && grp == GRP_LVL) |=> (((lvl ^ $past(lvl)) & ~{3{$past(wdata[31:24])}}) == '0));

   // R7
   sta_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && !masked && grp == GRP_CLR) |=> ((sta & $past(wdata[PORT_PINS-1:0]) & ~$past(set_i)) == '0));

   // R8
   sta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((sta & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int PORTS       = 4,
   parameter int PORT_PINS   = 8,
   parameter int MASK_OFS    = 'h80,
   parameter int SYNC_STAGES = 2,
   localparam int PINS       = PORTS * PORT_PINS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_en,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [BUS_W-1:0]       wdata,
   output logic [BUS_W-1:0]       rd_data,
   input  logic [PINS-1:0]        pad_in,
   output logic [PINS-1:0]        pad_out,
   output logic [PINS-1:0]        pad_oe,
   input  logic [PINS-1:0]        int_set,
   output logic [PINS-1:0]        int_sta,
   output logic [PINS-1:0]        int_enb,
   output logic [PORTS*LVL_W-1:0] int_lvl
);

   logic       hit;
   grp_e       grp;
   logic [1:0] port;
   logic       masked;

   gpio_bank_decode #(
      .ADDR_W   (ADDR_W),
      .PORTS    (PORTS),
      .MASK_OFS (MASK_OFS)
   ) u_dec (
      .addr   (addr),
      .hit    (hit),
      .grp    (grp),
      .port   (port),
      .masked (masked)
   );

   logic [PINS-1:0] in_s;

   gpio_in_sync #(
      .WIDTH  (PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_s)
   );

   logic [PORT_PINS-1:0] cnf_a [PORTS];
   logic [PORT_PINS-1:0] oe_a  [PORTS];
   logic [PORT_PINS-1:0] out_a [PORTS];
   logic [PORT_PINS-1:0] sta_a [PORTS];
   logic [PORT_PINS-1:0] enb_a [PORTS];
   logic [LVL_W-1:0]     lvl_a [PORTS];

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      logic wr_sel;
      assign wr_sel = wr_en && hit && (port == 2'(p));

      gpio_port_regs #(
         .PORT_PINS (PORT_PINS)
      ) u_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_sel (wr_sel),
         .grp    (grp),
         .masked (masked),
         .wdata  (wdata),
         .set_i  (int_set[p*PORT_PINS +: PORT_PINS]),
         .cnf    (cnf_a[p]),
         .oe     (oe_a[p]),
         .out    (out_a[p]),
         .sta    (sta_a[p]),
         .enb    (enb_a[p]),
         .lvl    (lvl_a[p])
      );

      assign pad_oe [p*PORT_PINS +: PORT_PINS] = cnf_a[p] & oe_a[p];
      assign pad_out[p*PORT_PINS +: PORT_PINS] = cnf_a[p] & oe_a[p] & out_a[p];
      assign int_sta[p*PORT_PINS +: PORT_PINS] = sta_a[p];
      assign int_enb[p*PORT_PINS +: PORT_PINS] = enb_a[p];
      assign int_lvl[p*LVL_W +: LVL_W]         = lvl_a[p];
   end

   logic [BUS_W-1:0] rsel;

   always_comb begin
      rsel = '0;
      if (hit) begin
         case (grp)
            GRP_CNF: rsel[PORT_PINS-1:0] = cnf_a[port];
            GRP_OE:  rsel[PORT_PINS-1:0] = oe_a[port];
            GRP_OUT: rsel[PORT_PINS-1:0] = out_a[port];
            GRP_IN:  rsel[PORT_PINS-1:0] = in_s[{port, 3'b000} +: PORT_PINS];
            GRP_STA: rsel[PORT_PINS-1:0] = sta_a[port];
            GRP_ENB: rsel[PORT_PINS-1:0] = enb_a[port];
            GRP_LVL: rsel[LVL_W-1:0]     = lvl_a[port];
            default: rsel = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rsel;
   end

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |=> (rd_data == '0));

   // R6
   in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && grp == GRP_IN) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(int_enb) && $stable(int_lvl)));

endmodule

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;
   logic [31:0] int_set = '0;
   logic [31:0] int_sta;
   logic [31:0] int_enb;
   logic [95:0] int_lvl;

   int n_chk  = 0;
   int n_fail = 0;
   logic pend = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   gpio_bank_regs uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rd_data (rd_data),
      .pad_in  (pad_in),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .int_set (int_set),
      .int_sta (int_sta),
      .int_enb (int_enb),
      .int_lvl (int_lvl)
   );

   task automatic check(input logic [95:0] act, input logic [95:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: rd_data is due one edge after rd_en
   always @(posedge clk) pend <= rd_en;

   always @(negedge clk) begin
      if (pend) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2: read with no expected item, actual %h expected none", rd_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({64'd0, rd_data}, {64'd0, e}, t);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rdwr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] e, input string tag);
      @(negedge clk);
      rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({64'd0, pad_oe}, 96'd0, "R1 pad_oe");
      check({64'd0, pad_out}, 96'd0, "R1 pad_out");
      check({64'd0, int_sta}, 96'd0, "R1 int_sta");
      check({64'd0, int_enb}, 96'd0, "R1 int_enb");
      check(int_lvl, 96'd0, "R1 int_lvl");
      rd(12'h004, 32'h0, "R1 cnf p1");
      rd(12'h064, 32'h0, "R1 lvl p1");

      // R2 plain map, R5 pads
      wr(12'h004, 32'h0000_00A5);
      wr(12'h014, 32'h0000_000F);
      wr(12'h024, 32'h0000_003C);
      rd(12'h004, 32'h0000_00A5, "R2 cnf p1");
      rd(12'h014, 32'h0000_000F, "R2 oe p1");
      rd(12'h024, 32'h0000_003C, "R2 out p1");
      check({64'd0, pad_oe}, {64'd0, 32'h0000_0500}, "R5 pad_oe");
      check({64'd0, pad_out}, {64'd0, 32'h0000_0400}, "R5 pad_out");

      // R3 masked byte writes
      wr(12'h084, 32'h0000_F00F);
      rd(12'h004, 32'h0000_0005, "R3 masked cnf");
      wr(12'h0A4, 32'h0000_0101);
      rd(12'h0A4, 32'h0000_003D, "R3 alias read out");
      check({64'd0, pad_out}, {64'd0, 32'h0000_0500}, "R5 pad_out after masked");

      // R4 trigger type
      wr(12'h068, 32'h00FF_00AA);
      rd(12'h068, 32'h00FF_00AA, "R4 plain lvl");
      wr(12'h0E8, 32'h0301_0203);
      rd(12'h068, 32'h00FD_02AB, "R4 masked lvl");
      check(int_lvl, {24'd0, 24'hFD02AB, 24'd0, 24'd0}, "R10 int_lvl");

      // R6 input sync
      @(negedge clk);
      pad_in = 32'hDEAD_BEEF;
      repeat (2) @(negedge clk);
      rd(12'h03C, 32'h0000_00DE, "R6 in p3");
      rd(12'h030, 32'h0000_00EF, "R6 in p0");
      wr(12'h030, 32'h0000_0055);
      rd(12'h030, 32'h0000_00EF, "R6 in write ignored");

      // R8 set, R7 clear
      @(negedge clk);
      int_set = 32'h0000_8100;
      @(negedge clk);
      int_set = 32'h0;
      check({64'd0, int_sta}, {64'd0, 32'h0000_8100}, "R10 int_sta");
      rd(12'h044, 32'h0000_0081, "R8 sta p1");
      wr(12'h074, 32'h0000_0001);
      rd(12'h044, 32'h0000_0080, "R7 clear");
      rd(12'h074, 32'h0, "R7 clr reads zero");
      wr(12'h040, 32'h0000_0033);
      rd(12'h040, 32'h0000_0033, "R7 sta load");
      wr(12'h0C0, 32'h0000_0F00);
      rd(12'h040, 32'h0000_0030, "R7 sta masked");
      wr(12'h05C, 32'h0000_0077);
      check({64'd0, int_enb}, {64'd0, 32'h7700_0000}, "R10 int_enb");

      // R8 set beats clear
      @(negedge clk);
      int_set = 32'h8000_0000;
      wr_en = 1'b1; addr = 12'h07C; wdata = 32'h0000_0080;
      @(negedge clk);
      int_set = 32'h0; wr_en = 1'b0;
      rd(12'h04C, 32'h0000_0080, "R8 set wins");

      // R9 unmapped
      rd(12'h104, 32'h0, "R9 above range");
      rd(12'h0B0, 32'h0, "R9 masked in");
      rd(12'h006, 32'h0, "R9 misaligned");
      wr(12'h0F4, 32'h0000_FFFF);
      check({64'd0, int_sta}, {64'd0, 32'h8000_8030}, "R9 masked clr ignored");
      wr(12'h104, 32'h0000_00FF);
      rd(12'h004, 32'h0000_0005, "R9 write ignored");

      // R11 read during write
      rdwr(12'h014, 32'h0000_00FF, 32'h0000_000F, "R11 old value");
      rd(12'h014, 32'h0000_00FF, "R11 new value");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2: actual %0d pending reads expected 0", exp_q.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule